// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software uses a small 32-bit register bus to set each pin's direction, output drive and output level, and to read back the pin state after it has been synchronised. A per-pin ownership select can give a pad to an alternate on-chip function instead. When that select is set, the alternate function's level and drive enable reach the pad directly, and the raw pad level is always forwarded to it.

Each pin also has an interrupt detector. A pin can be level-sensitive (active high or low) or edge-sensitive (rising, falling, or both). Detected events latch into a pending register. Reading that register returns the pending set and clears it in the same access, so there is no acknowledge register. Each pin's mask can only change through two write-one registers: one unmasks and the other masks. A single interrupt line goes high while any pending pin is unmasked.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input, every interrupt is masked, pending is clear, drive enables and output levels are 0, all detectors are falling-edge (sense 0, polarity 0, both-edges 0), and every pin is owned by the alternate function.
- R2: When the GPIO registers own a pin, `pad_oe` is high only if that pin's direction bit is 0 (output) and its drive-enable bit is 1. `pad_out` follows the output-level bit. A direction bit of 1 makes the drive enable have no effect.
- R3: When a pin's ownership bit is 1, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe`. `alt_in` always mirrors `pad_in`.
- R4: Writing a 1 to bit i at 0x18 clears mask bit i, and writing a 1 at 0x1C sets it. Zero bits change nothing. The mask reads at 0x14 with 1 meaning masked, and a write to 0x14 itself has no effect.
- R5: `pad_in` passes through a two-flop synchroniser before the pin-state register at 0x10 and before detection. A read issued in the cycle after a pad change still returns the old level, and the next read returns the new one.
- R6: With sense bit 0 (0x24), the event is an edge. Polarity bit (0x28) 1 selects rising and 0 selects falling. Both-edges bit (0x2C) 1 makes either edge an event.
- R7: With sense bit 1, the event is a level: high when polarity is 1, low when polarity is 0. A level that is still active stays pending across a clearing read, because a new event beats the clear in the same cycle.
- R8: A read of 0x20 returns the pending bits and clears them all at the same clock edge. Writes to 0x20 are ignored.
- R9: With NPINS below 32, register bits at and above NPINS read as 0 and ignore writes.
- R10: `irq_out` is high exactly when some pending bit has its mask bit clear.
- R11: Word offsets are 0x00 ownership, 0x04 direction, 0x08 drive enable, 0x0C output level, 0x10 pin state (read-only), 0x14 mask (read-only), 0x18 unmask (write-only, reads 0), 0x1C set-mask (write-only, reads 0), 0x20 pending, 0x24 sense, 0x28 polarity and 0x2C both-edges. Read data is registered and appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; pending register clears on it |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad drive enables |
| alt_out | input | NPINS | Alternate-function output levels |
| alt_oe | input | NPINS | Alternate-function drive enables |
| alt_in | output | NPINS | Pad levels forwarded to the alternate function |
| irq_out | output | 1 | Combined unmasked interrupt |

## Verification
On every cycle, the assertions check the pad ownership muxing and that input pins are never driven. They also check that an unmask write takes effect on the following cycle and that an all-ones mask write silences the interrupt line. Further per-cycle checks are that a detected event always lands in pending, that a clearing read with no new event empties pending, and that bits above the pin count read as 0. Only the bench scenarios can show the following:
- the two-cycle synchroniser latency seen through reads;
- which edge or level each sense, polarity and both-edges setting responds to;
- the difference between a level source re-arming and an edge source staying clear after a read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned PIN_LIMIT = 32;

   localparam int unsigned OFS_OWN     = 'h00;
   localparam int unsigned OFS_DIR     = 'h04;
   localparam int unsigned OFS_DRVEN   = 'h08;
   localparam int unsigned OFS_DRVVAL  = 'h0C;
   localparam int unsigned OFS_PIN     = 'h10;
   localparam int unsigned OFS_MASK    = 'h14;
   localparam int unsigned OFS_UNMASK  = 'h18;
   localparam int unsigned OFS_SETMASK = 'h1C;
   localparam int unsigned OFS_PEND    = 'h20;
   localparam int unsigned OFS_SENSE   = 'h24;
   localparam int unsigned OFS_POL     = 'h28;
   localparam int unsigned OFS_BOTH    = 'h2C;

   typedef enum logic [3:0] {
      RS_OWN, RS_DIR, RS_DRVEN, RS_DRVVAL, RS_PIN, RS_MASK,
      RS_UNMASK, RS_SETMASK, RS_PEND, RS_SENSE, RS_POL, RS_BOTH, RS_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_reg(input logic [31:0] a);
      case (a)
         32'(OFS_OWN):     return RS_OWN;
         32'(OFS_DIR):     return RS_DIR;
         32'(OFS_DRVEN):   return RS_DRVEN;
         32'(OFS_DRVVAL):  return RS_DRVVAL;
         32'(OFS_PIN):     return RS_PIN;
         32'(OFS_MASK):    return RS_MASK;
         32'(OFS_UNMASK):  return RS_UNMASK;
         32'(OFS_SETMASK): return RS_SETMASK;
         32'(OFS_PEND):    return RS_PEND;
         32'(OFS_SENSE):   return RS_SENSE;
         32'(OFS_POL):     return RS_POL;
         32'(OFS_BOTH):    return RS_BOTH;
         default:          return RS_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] smp,
   input  logic [NPINS-1:0] sense,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] both,
   output logic [NPINS-1:0] evt
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic rise, fall, lvl, edg;
      assign rise   = smp[i] & ~prev_q[i];
      assign fall   = ~smp[i] & prev_q[i];
      assign lvl    = pol[i] ? smp[i] : ~smp[i];
      assign edg    = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
      assign evt[i] = sense[i] ? lvl : edg;
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_state,
   input  logic [NPINS-1:0]  evt,
   output logic [NPINS-1:0]  bypass_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  drv_en_q,
   output logic [NPINS-1:0]  drv_val_q,
   output logic [NPINS-1:0]  mask_q,
   output logic [NPINS-1:0]  sense_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  both_q,
   output logic [NPINS-1:0]  status_q
);
   reg_sel_e         sel;
   logic [NPINS-1:0] wd;
   logic [NPINS-1:0] rsel;
   logic             pend_clr;

   assign sel      = decode_reg(32'(bus_addr));
   assign wd       = bus_wdata[NPINS-1:0];
   assign pend_clr = bus_rd && (sel == RS_PEND);

   if (NPINS < DATA_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NPINS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bypass_q  <= '1;
         dir_q     <= '1;
         drv_en_q  <= '0;
         drv_val_q <= '0;
         mask_q    <= '1;
         sense_q   <= '0;
         pol_q     <= '0;
         both_q    <= '0;
      end else if (bus_wr) begin
         case (sel)
            RS_OWN:     bypass_q  <= wd;
            RS_DIR:     dir_q     <= wd;
            RS_DRVEN:   drv_en_q  <= wd;
            RS_DRVVAL:  drv_val_q <= wd;
            RS_UNMASK:  mask_q    <= mask_q & ~wd;
            RS_SETMASK: mask_q    <= mask_q | wd;
            RS_SENSE:   sense_q   <= wd;
            RS_POL:     pol_q     <= wd;
            RS_BOTH:    both_q    <= wd;
            default:    ;
         endcase
      end
   end

   // pending: a new event outranks a clearing read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (pend_clr ? '0 : status_q) | evt;
   end

   always_comb begin
      case (sel)
         RS_OWN:    rsel = bypass_q;
         RS_DIR:    rsel = dir_q;
         RS_DRVEN:  rsel = drv_en_q;
         RS_DRVVAL: rsel = drv_val_q;
         RS_PIN:    rsel = pin_state;
         RS_MASK:   rsel = mask_q;
         RS_PEND:   rsel = status_q;
         RS_SENSE:  rsel = sense_q;
         RS_POL:    rsel = pol_q;
         RS_BOTH:   rsel = both_q;
         default:   rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= DATA_W'(rsel);
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  alt_in,
   output logic              irq_out
);
   if (NPINS < 1 || NPINS > PIN_LIMIT) begin : g_bad_npins
      $error("NPINS must lie in 1..32");
   end
   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 6..32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] pin_state;
   logic [NPINS-1:0] evt;
   logic [NPINS-1:0] bypass_q, dir_q, drv_en_q, drv_val_q;
   logic [NPINS-1:0] mask_q, sense_q, pol_q, both_q, status_q;

   gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_state)
   );

   gpio_irq_detect #(.NPINS(NPINS)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (pin_state),
      .sense(sense_q),
      .pol  (pol_q),
      .both (both_q),
      .evt  (evt)
   );

   gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .pin_state(pin_state),
      .evt      (evt),
      .bypass_q (bypass_q),
      .dir_q    (dir_q),
      .drv_en_q (drv_en_q),
      .drv_val_q(drv_val_q),
      .mask_q   (mask_q),
      .sense_q  (sense_q),
      .pol_q    (pol_q),
      .both_q   (both_q),
      .status_q (status_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pad
      assign pad_out[i] = bypass_q[i] ? alt_out[i] : drv_val_q[i];
      assign pad_oe[i]  = bypass_q[i] ? alt_oe[i]  : (drv_en_q[i] & ~dir_q[i]);
   end

   assign alt_in  = pad_in;
   assign irq_out = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  alt_out,
   input logic              irq_out,
   input logic [NPINS-1:0]  bypass_q,
   input logic [NPINS-1:0]  dir_q,
   input logic [NPINS-1:0]  mask_q,
   input logic [NPINS-1:0]  status_q,
   input logic [NPINS-1:0]  evt
);
   AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~bypass_q & dir_q & pad_oe) == '0)); // R2

   AST_ALT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      ((bypass_q & (pad_out ^ alt_out)) == '0)); // R3

   AST_UNMASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_UNMASK))
      |=> ((mask_q & $past(bus_wdata[NPINS-1:0])) == '0)); // R4

   AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status_q & $past(evt)) == $past(evt))); // R7

   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_PEND) && evt == '0)
      |=> (status_q == '0)); // R8

   if (NPINS < DATA_W) begin : g_hi
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rdata[DATA_W-1:NPINS] == '0)); // R9
   end

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_SETMASK) && (&bus_wdata[NPINS-1:0]))
      |=> !irq_out); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .alt_out  (alt_out),
   .irq_out  (irq_out),
   .bypass_q (bypass_q),
   .dir_q    (dir_q),
   .mask_q   (mask_q),
   .status_q (status_q),
   .evt      (evt)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
   localparam int unsigned N  = 24;
   localparam int unsigned AW = 8;
   localparam logic [31:0] PM = (32'h1 << N) - 1;

   localparam logic [7:0] A_OWN = 8'h00, A_DIR = 8'h04, A_DEN = 8'h08, A_DVAL = 8'h0C,
                          A_PIN = 8'h10, A_MASK = 8'h14, A_UNM = 8'h18, A_SETM = 8'h1C,
                          A_PEND = 8'h20, A_SENSE = 8'h24, A_POL = 8'h28, A_BOTH = 8'h2C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe;
   logic [N-1:0]  alt_out = '0;
   logic [N-1:0]  alt_oe = '0;
   logic [N-1:0]  alt_in;
   logic          irq_out;

   int n_chk = 0;
   int n_bad = 0;

   // shadow of the pad-facing registers
   logic [N-1:0] m_own, m_dir, m_den, m_dval;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.NPINS(N), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq_out(irq_out)
   );

   function automatic logic [N-1:0] exp_oe();
      return (m_own & alt_oe) | (~m_own & m_den & ~m_dir);
   endfunction

   function automatic logic [N-1:0] exp_out();
      return (m_own & alt_out) | (~m_own & m_dval);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hang expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [N-1:0] r;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      m_own = '1; m_dir = '1; m_den = '0; m_dval = '0;
      check("R1 irq", 32'(irq_out), 0);
      check("R1 oe", 32'(pad_oe), 0);
      alt_oe = '1; #1;
      check("R3 alt owns after reset", 32'(pad_oe), PM);
      alt_oe = '0;
      rd(A_OWN, d);  check("R1 own", d, PM);
      rd(A_DIR, d);  check("R1 dir", d, PM);
      rd(A_MASK, d); check("R1 mask", d, PM);
      rd(A_PEND, d); check("R1 pend", d, 0);
      rd(A_DEN, d);  check("R1 drven", d, 0);
      rd(A_SENSE, d); check("R1 sense", d, 0);

      // R9 upper bits
      wr(A_DVAL, 32'hFFFF_FFFF); m_dval = '1;
      rd(A_DVAL, d); check("R9 upper bits", d, PM);
      // R11 write-only registers read zero
      rd(A_UNM, d); check("R11 unmask reads 0", d, 0);

      // R2 R3 random pad control
      for (int k = 0; k < 200; k++) begin
         logic [31:0] v;
         int sel;
         v   = $urandom();
         sel = $urandom_range(0, 3);
         alt_out = N'($urandom());
         alt_oe  = N'($urandom());
         case (sel)
            0: begin wr(A_OWN, v);  m_own  = v[N-1:0]; end
            1: begin wr(A_DIR, v);  m_dir  = v[N-1:0]; end
            2: begin wr(A_DEN, v);  m_den  = v[N-1:0]; end
            default: begin wr(A_DVAL, v); m_dval = v[N-1:0]; end
         endcase
         check("R2 R3 pad_oe", 32'(pad_oe), 32'(exp_oe()));
         check("R2 R3 pad_out", 32'(pad_out), 32'(exp_out()));
         check("R3 alt_in", 32'(alt_in), 32'(pad_in));
         pad_in = N'($urandom());
      end
      rd(A_DIR, d); check("R2 dir readback", d, 32'(m_dir));

      // R5 synchroniser latency
      pad_in = '0; idle(4);
      r = N'($urandom()) | N'(1);
      pad_in = r;
      rd(A_PIN, d); check("R5 old value one read later", d, 0);
      rd(A_PIN, d); check("R5 new value", d, 32'(r));
      pad_in = '0; idle(5);
      rd(A_PEND, d);
      rd(A_PEND, d); check("R8 cleared by read", d, 0);
      wr(A_PEND, 32'hFF); rd(A_PEND, d); check("R8 write ignored", d, 0);

      // R4 mask handling
      wr(A_UNM, 32'hFF00_0028);
      rd(A_MASK, d); check("R4 unmask 3,5", d, PM & ~32'h28);
      wr(A_MASK, 0);
      rd(A_MASK, d); check("R4 direct write ignored", d, PM & ~32'h28);
      wr(A_SETM, 32'h20); wr(A_UNM, 32'h20);
      rd(A_MASK, d); check("R4 set then clear", d, PM & ~32'h28);

      // R7 level high on pin 3
      wr(A_SENSE, 32'h8); wr(A_POL, 32'h8);
      rd(A_PEND, d);
      check("R10 idle", 32'(irq_out), 0);
      pad_in[3] = 1'b1; idle(5);
      check("R10 unmasked pending", 32'(irq_out), 1);
      rd(A_PEND, d); check("R8 pending returned", d, 32'h8);
      rd(A_PEND, d); check("R7 level re-arms", d, 32'h8);
      pad_in[3] = 1'b0; idle(5);
      rd(A_PEND, d);
      rd(A_PEND, d); check("R7 inactive level", d, 0);
      check("R10 cleared", 32'(irq_out), 0);

      // R7 level low on pin 9
      wr(A_SENSE, 32'h208); idle(3);
      rd(A_PEND, d); check("R7 level low", d, 32'h200);
      pad_in[9] = 1'b1; idle(5);
      rd(A_PEND, d);
      rd(A_PEND, d); check("R7 level low released", d, 0);

      // R6 rising on pin 5
      wr(A_POL, 32'h28);
      pad_in[5] = 1'b1; idle(5);
      check("R10 edge pending", 32'(irq_out), 1);
      rd(A_PEND, d); check("R6 rising", d, 32'h20);
      rd(A_PEND, d); check("R6 edge does not re-arm", d, 0);
      check("R10 after clear", 32'(irq_out), 0);
      pad_in[5] = 1'b0; idle(5);
      rd(A_PEND, d); check("R6 falling ignored when rising", d, 0);

      // R6 both edges on pin 6
      wr(A_BOTH, 32'h40);
      pad_in[6] = 1'b1; idle(5);
      rd(A_PEND, d); check("R6 both rise", d, 32'h40);
      pad_in[6] = 1'b0; idle(5);
      rd(A_PEND, d); check("R6 both fall", d, 32'h40);

      // R6 default falling on masked pin 7
      pad_in[7] = 1'b1; idle(5);
      rd(A_PEND, d); check("R6 rising ignored when falling", d, 0);
      pad_in[7] = 1'b0; idle(5);
      check("R10 masked pin quiet", 32'(irq_out), 0);
      rd(A_PEND, d); check("R6 falling", d, 32'h80);

      // R10 mask all while level pending
      pad_in[3] = 1'b1; idle(5);
      check("R10 pending before mask", 32'(irq_out), 1);
      wr(A_SETM, 32'hFFFF_FFFF);
      check("R10 all masked", 32'(irq_out), 0);
      rd(A_MASK, d); check("R4 all masked", d, PM);

      idle(2);
      summary();
      $finish;
   end
endmodule